// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the write side of an 8-bit parallel flash bus. It watches each write cycle (address, data and an active-low write strobe), all sampled on the chip clock. It recognises the multi-write command sequences that a flash part accepts. Each command begins with two unlock writes at fixed key addresses. The command byte then follows, and some commands need further writes. When a sequence completes, the block raises a one-cycle start pulse for the operation engine. The pulse comes with an operation code and the address and data of the final write.

The block also keeps an identification-mode flag, so that the read path can show identification data instead of array contents. While the engine reports busy, the block ignores every write. A strobe that stays low for too few clocks counts as noise: it neither moves a sequence forward nor breaks it.

The decoder is a state machine with seven states:
- `ST_READ`: idle, read mode.
- `ST_UNLOCK1`: the first unlock write has been seen.
- `ST_UNLOCK2`: both unlock writes have been seen.
- `ST_PROG_ARMED`: waiting for the program target write.
- `ST_ERASE_ARMED`: the erase prefix has been seen.
- `ST_ERASE_U1` and `ST_ERASE_U2`: the second unlock pair of a six-write sequence.

Transitions:
- ST_READ→ST_UNLOCK1 on AA@5555.
- ST_UNLOCK1→ST_UNLOCK2 on 55@2AAA.
- ST_UNLOCK2→ST_PROG_ARMED on A0@5555.
- ST_UNLOCK2→ST_ERASE_ARMED on 80@5555.
- ST_UNLOCK2→ST_READ with an identification start on 90 or F0 at 5555.
- ST_PROG_ARMED→ST_READ with a program start.
- ST_ERASE_ARMED→ST_ERASE_U1→ST_ERASE_U2 on the unlock pair.
- ST_ERASE_U2→ST_READ with an erase or lockout start.
- Any non-matching accepted write returns to ST_READ.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset op_start is 0, op_kind is 0, id_mode is 0 and the decoder is in read mode.
- R2: A write is taken with its address at the clock that first samples bus_we_n low and its data at the clock that first samples it high again. It counts only if bus_we_n was sampled low on at least MIN_LOW clocks (default 2). A shorter pulse neither advances nor breaks a sequence.
- R3: Every multi-write command starts with data AA at key address 5555, then data 55 at address 2AAA. Only address bits [15:0] are compared, so bit 16 is ignored.
- R4: Unlock, then A0 at 5555, then any write gives op_kind 1 (program). op_addr carries the full 17-bit address of that write and op_data its data.
- R5: Unlock, 80 at 5555, unlock, then 10 at 5555 gives op_kind 2 (chip erase).
- R6: The same prefix followed by 30 at any address gives op_kind 3 (sector erase), with op_addr equal to that write's address.
- R7: The same prefix followed by 40 at 5555 gives op_kind 4 (boot lockout enable).
- R8: Unlock then 90 at 5555 gives op_kind 5 (identification entry) and sets id_mode.
- R9: Unlock then F0 at 5555, or a single F0 at any address written in read mode, gives op_kind 6 (identification exit) and clears id_mode.
- R10: An accepted write that does not match the next expected step returns the decoder to read mode without a start. That write is not reused as the first step of a new sequence.
- R11: A write that completes while op_busy is 1 is discarded. The decoder state and id_mode stay unchanged.
- R12: op_start is high for exactly one cycle. It is registered on the clock edge after the edge that samples the final rising strobe. op_kind, op_addr and op_data hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 17 | Bus address |
| bus_data | input | 8 | Bus write data |
| bus_we_n | input | 1 | Active-low write strobe |
| op_busy | input | 1 | Operation engine busy |
| op_start | output | 1 | One-cycle operation request |
| op_kind | output | 3 | Operation code (0 none, 1 program, 2 chip erase, 3 sector erase, 4 lockout, 5 id entry, 6 id exit) |
| op_addr | output | 17 | Address of the final write |
| op_data | output | 8 | Data of the final write |
| id_mode | output | 1 | Identification mode active |

## Verification
The assertions check several rules on every cycle:
- the accepted-write and start pulses last one cycle only;
- no start follows a write completed while busy, and the decoder state holds while busy;
- id_mode changes only together with a matching identification start.

Only the bench's scenarios can show that each byte value decodes correctly, since that depends on ordered write sequences. The bench sweeps all 256 command bytes at both the third-write and sixth-write positions. It also covers:
- strobe-length filtering and unlock breaks;
- 17-bit address pass-through;
- the exact cycle on which the start pulse appears.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam logic [15:0] KEY_ADDR  = 16'h5555;
    localparam logic [15:0] ALT_ADDR  = 16'h2AAA;
    localparam logic [7:0]  UNLOCK_A  = 8'hAA;
    localparam logic [7:0]  UNLOCK_B  = 8'h55;
    localparam logic [7:0]  BYTE_PROG = 8'hA0;
    localparam logic [7:0]  BYTE_ERAS = 8'h80;
    localparam logic [7:0]  BYTE_IDIN = 8'h90;
    localparam logic [7:0]  BYTE_EXIT = 8'hF0;
    localparam logic [7:0]  BYTE_CHIP = 8'h10;
    localparam logic [7:0]  BYTE_SECT = 8'h30;
    localparam logic [7:0]  BYTE_LOCK = 8'h40;

    typedef enum logic [2:0] {
        OP_NONE         = 3'd0,
        OP_PROGRAM      = 3'd1,
        OP_CHIP_ERASE   = 3'd2,
        OP_SECTOR_ERASE = 3'd3,
        OP_LOCKOUT      = 3'd4,
        OP_ID_ENTER     = 3'd5,
        OP_ID_EXIT      = 3'd6
    } op_kind_e;

    typedef enum logic [2:0] {
        CODE_OTHER,
        CODE_PROG,
        CODE_ERASE,
        CODE_ID_IN,
        CODE_EXIT,
        CODE_CHIP,
        CODE_SECTOR,
        CODE_LOCK
    } cmd_code_e;

    typedef enum logic [2:0] {
        ST_READ,
        ST_UNLOCK1,
        ST_UNLOCK2,
        ST_PROG_ARMED,
        ST_ERASE_ARMED,
        ST_ERASE_U1,
        ST_ERASE_U2
    } seq_state_e;

    typedef struct packed {
        logic      key_hit;
        logic      unlock1;
        logic      unlock2;
        cmd_code_e code;
    } wr_class_t;

endpackage

// File: rtl/flash_strobe_filter.sv
module flash_strobe_filter #(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int MIN_LOW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int               CNT_W   = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] LOW_LIM = CNT_W'(MIN_LOW);

    logic             we_q;
    logic [CNT_W-1:0] low_cnt;
    logic             fall_seen;
    logic             rise_seen;

    assign fall_seen = we_q && !we_n;
    assign rise_seen = !we_q && we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q     <= 1'b1;
            low_cnt  <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            we_q     <= we_n;
            wr_valid <= 1'b0;
            if (fall_seen) begin
                wr_addr <= addr;
                low_cnt <= CNT_W'(1);
            end else if (!we_q && !we_n) begin
                if (low_cnt < LOW_LIM) begin
                    low_cnt <= low_cnt + 1'b1;
                end
            end else if (rise_seen) begin
                wr_data  <= data;
                wr_valid <= (low_cnt >= LOW_LIM);
            end
        end
    end

    // R2: a completed write is reported for a single cycle
    assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

endmodule

// File: rtl/flash_cmd_classify.sv
module flash_cmd_classify
    import flash_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [15:0]       key_addr,
    input  logic [DATA_W-1:0] data,
    output wr_class_t         cls
);

    logic at_key;
    logic at_alt;

    assign at_key = (key_addr == KEY_ADDR);
    assign at_alt = (key_addr == ALT_ADDR);

    always_comb begin
        cls.key_hit = at_key;
        cls.unlock1 = at_key && (data == DATA_W'(UNLOCK_A));
        cls.unlock2 = at_alt && (data == DATA_W'(UNLOCK_B));
        if (data == DATA_W'(BYTE_PROG)) begin
            cls.code = CODE_PROG;
        end else if (data == DATA_W'(BYTE_ERAS)) begin
            cls.code = CODE_ERASE;
        end else if (data == DATA_W'(BYTE_IDIN)) begin
            cls.code = CODE_ID_IN;
        end else if (data == DATA_W'(BYTE_EXIT)) begin
            cls.code = CODE_EXIT;
        end else if (data == DATA_W'(BYTE_CHIP)) begin
            cls.code = CODE_CHIP;
        end else if (data == DATA_W'(BYTE_SECT)) begin
            cls.code = CODE_SECTOR;
        end else if (data == DATA_W'(BYTE_LOCK)) begin
            cls.code = CODE_LOCK;
        end else begin
            cls.code = CODE_OTHER;
        end
    end

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              op_busy,
    input  wr_class_t         cls,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              op_start,
    output op_kind_e          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode
);

    seq_state_e state, state_nxt;
    logic       start_nxt;
    op_kind_e   kind_nxt;
    logic       accept;

    assign accept = wr_valid && !op_busy;

    always_comb begin
        state_nxt = state;
        start_nxt = 1'b0;
        kind_nxt  = OP_NONE;
        if (accept) begin
            unique case (state)
                ST_READ: begin
                    if (cls.unlock1) begin
                        state_nxt = ST_UNLOCK1;
                    end else if (cls.code == CODE_EXIT) begin
                        start_nxt = 1'b1;
                        kind_nxt  = OP_ID_EXIT;
                    end
                end
                ST_UNLOCK1: begin
                    state_nxt = cls.unlock2 ? ST_UNLOCK2 : ST_READ;
                end
                ST_UNLOCK2: begin
                    state_nxt = ST_READ;
                    if (cls.key_hit) begin
                        case (cls.code)
                            CODE_PROG:  state_nxt = ST_PROG_ARMED;
                            CODE_ERASE: state_nxt = ST_ERASE_ARMED;
                            CODE_ID_IN: begin
                                start_nxt = 1'b1;
                                kind_nxt  = OP_ID_ENTER;
                            end
                            CODE_EXIT: begin
                                start_nxt = 1'b1;
                                kind_nxt  = OP_ID_EXIT;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_PROG_ARMED: begin
                    state_nxt = ST_READ;
                    start_nxt = 1'b1;
                    kind_nxt  = OP_PROGRAM;
                end
                ST_ERASE_ARMED: begin
                    state_nxt = cls.unlock1 ? ST_ERASE_U1 : ST_READ;
                end
                ST_ERASE_U1: begin
                    state_nxt = cls.unlock2 ? ST_ERASE_U2 : ST_READ;
                end
                ST_ERASE_U2: begin
                    state_nxt = ST_READ;
                    if (cls.code == CODE_SECTOR) begin
                        start_nxt = 1'b1;
                        kind_nxt  = OP_SECTOR_ERASE;
                    end else if (cls.key_hit && cls.code == CODE_CHIP) begin
                        start_nxt = 1'b1;
                        kind_nxt  = OP_CHIP_ERASE;
                    end else if (cls.key_hit && cls.code == CODE_LOCK) begin
                        start_nxt = 1'b1;
                        kind_nxt  = OP_LOCKOUT;
                    end
                end
                default: state_nxt = ST_READ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_READ;
        end else begin
            state <= state_nxt;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_start <= 1'b0;
            op_kind  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
            id_mode  <= 1'b0;
        end else begin
            op_start <= start_nxt;
            if (start_nxt) begin
                op_kind <= kind_nxt;
                op_addr <= wr_addr;
                op_data <= wr_data;
                if (kind_nxt == OP_ID_ENTER) begin
                    id_mode <= 1'b1;
                end else if (kind_nxt == OP_ID_EXIT) begin
                    id_mode <= 1'b0;
                end
            end
        end
    end

    // R12: start lasts a single cycle
    assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    // R12: every start follows a completed write
    assert_start_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(wr_valid));

    // R11: a write during busy never yields a start
    assert_busy_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && op_busy) |=> !op_start);

    // R11: decoder state holds while busy
    assert_state_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy |=> $stable(state));

    // R8: identification mode turns on only with an entry start
    assert_id_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> (op_start && op_kind == OP_ID_ENTER));

    // R9: identification mode turns off only with an exit start
    assert_id_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(id_mode) |-> (op_start && op_kind == OP_ID_EXIT));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int MIN_LOW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_we_n,
    input  logic              op_busy,
    output logic              op_start,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode
);

    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    wr_class_t         cls;
    op_kind_e          kind_w;

    flash_strobe_filter #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .MIN_LOW (MIN_LOW)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_n     (bus_we_n),
        .addr     (bus_addr),
        .data     (bus_data),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    flash_cmd_classify #(
        .DATA_W (DATA_W)
    ) u_class (
        .key_addr (wr_addr[15:0]),
        .data     (wr_data),
        .cls      (cls)
    );

    flash_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .op_busy  (op_busy),
        .cls      (cls),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .op_start (op_start),
        .op_kind  (kind_w),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .id_mode  (id_mode)
    );

    assign op_kind = kind_w;

endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        bus_we_n = 1'b1;
    logic        op_busy = 1'b0;
    logic        op_start;
    logic [2:0]  op_kind;
    logic [16:0] op_addr;
    logic [7:0]  op_data;
    logic        id_mode;

    int checks = 0;
    int fails  = 0;
    int n_start = 0;
    logic [2:0]  last_kind = '0;
    logic [16:0] last_addr = '0;
    logic [7:0]  last_data = '0;
    bit exp_id = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_seq dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_data (bus_data),
        .bus_we_n (bus_we_n),
        .op_busy  (op_busy),
        .op_start (op_start),
        .op_kind  (op_kind),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .id_mode  (id_mode)
    );

    always @(negedge clk) begin
        if (rst_n && op_start) begin
            n_start   = n_start + 1;
            last_kind = op_kind;
            last_addr = op_addr;
            last_data = op_data;
        end
    end

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [16:0] a, input logic [7:0] d, input int low = 2);
        @(negedge clk);
        bus_addr = a;
        bus_data = d;
        bus_we_n = 1'b0;
        repeat (low) @(negedge clk);
        bus_we_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic unlock();
        bus_wr(17'h05555, 8'hAA);
        bus_wr(17'h02AAA, 8'h55);
    endtask

    task automatic expect_op(input string req, input int base, input bit want,
                             input logic [2:0] kind, input logic [16:0] a,
                             input logic [7:0] d);
        if (want) begin
            check_eq(req, "start count", n_start, base + 1);
            check_eq(req, "kind", last_kind, kind);
            check_eq(req, "addr", last_addr, a);
            check_eq(req, "data", last_data, d);
        end else begin
            check_eq(req, "no start", n_start, base);
        end
        check_eq(req, "id_mode", id_mode, exp_id);
    endtask

    function automatic logic [2:0] kind_third(input logic [7:0] d);
        if (d == 8'h90) return 3'd5;
        if (d == 8'hF0) return 3'd6;
        return 3'd0;
    endfunction

    function automatic logic [2:0] kind_sixth(input logic [7:0] d);
        if (d == 8'h10) return 3'd2;
        if (d == 8'h30) return 3'd3;
        if (d == 8'h40) return 3'd4;
        return 3'd0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R12 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        logic [2:0] k;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1", "op_start", op_start, 0);
        check_eq("R1", "op_kind", op_kind, 0);
        check_eq("R1", "id_mode", id_mode, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: decoder starts in read mode: full program works at once
        base = n_start;
        unlock();
        bus_wr(17'h05555, 8'hA0);
        bus_wr(17'h00123, 8'h3C);
        expect_op("R1", base, 1'b1, 3'd1, 17'h00123, 8'h3C);

        // R4 R8 R9: sweep every third-write command byte
        for (int d = 0; d < 256; d++) begin
            base = n_start;
            unlock();
            bus_wr(17'h05555, 8'(d));
            if (d == 8'hA0) begin
                bus_wr(17'(d * 17'd301), 8'(d ^ 8'h5A));
                expect_op("R4", base, 1'b1, 3'd1, 17'(d * 17'd301), 8'(d ^ 8'h5A));
            end else if (d == 8'h80) begin
                unlock();
                bus_wr(17'h05555, 8'h10);
                expect_op("R5", base, 1'b1, 3'd2, 17'h05555, 8'h10);
            end else begin
                k = kind_third(8'(d));
                if (k == 3'd5) exp_id = 1'b1;
                if (k == 3'd6) exp_id = 1'b0;
                expect_op(k == 3'd5 ? "R8" : (k == 3'd6 ? "R9" : "R10"),
                          base, k != 3'd0, k, 17'h05555, 8'(d));
            end
        end

        // R5 R6 R7: sweep every sixth-write command byte
        for (int d = 0; d < 256; d++) begin
            base = n_start;
            unlock();
            bus_wr(17'h05555, 8'h80);
            unlock();
            bus_wr(17'h05555, 8'(d));
            k = kind_sixth(8'(d));
            expect_op(k == 3'd2 ? "R5" : (k == 3'd3 ? "R6" : (k == 3'd4 ? "R7" : "R10")),
                      base, k != 3'd0, k, 17'h05555, 8'(d));
        end

        // R6: sector erase at an arbitrary address passes it through
        base = n_start;
        unlock(); bus_wr(17'h05555, 8'h80); unlock();
        bus_wr(17'h1A123, 8'h30);
        expect_op("R6", base, 1'b1, 3'd3, 17'h1A123, 8'h30);

        // R7: lockout byte away from the key address gives no start
        base = n_start;
        unlock(); bus_wr(17'h05555, 8'h80); unlock();
        bus_wr(17'h04444, 8'h40);
        expect_op("R7", base, 1'b0, 3'd0, 17'h0, 8'h0);

        // R3: address bit 16 ignored in key comparison, kept in target
        base = n_start;
        bus_wr(17'h15555, 8'hAA);
        bus_wr(17'h12AAA, 8'h55);
        bus_wr(17'h15555, 8'hA0);
        bus_wr(17'h1ABCD, 8'h77);
        expect_op("R3", base, 1'b1, 3'd1, 17'h1ABCD, 8'h77);

        // R9: single F0 anywhere leaves identification mode
        unlock(); bus_wr(17'h05555, 8'h90); exp_id = 1'b1;
        check_eq("R8", "id_mode set", id_mode, 1);
        base = n_start;
        bus_wr(17'h01234, 8'hF0); exp_id = 1'b0;
        expect_op("R9", base, 1'b1, 3'd6, 17'h01234, 8'hF0);

        // R10: broken unlock then program bytes give nothing
        base = n_start;
        bus_wr(17'h05555, 8'hAA);
        bus_wr(17'h02AAB, 8'h55);
        bus_wr(17'h05555, 8'hA0);
        bus_wr(17'h00010, 8'h11);
        expect_op("R10", base, 1'b0, 3'd0, 17'h0, 8'h0);
        // R10: the breaking AA is not reused as a new first step
        base = n_start;
        bus_wr(17'h05555, 8'hAA);
        bus_wr(17'h05555, 8'hAA);
        bus_wr(17'h02AAA, 8'h55);
        bus_wr(17'h05555, 8'hA0);
        bus_wr(17'h00020, 8'h22);
        expect_op("R10", base, 1'b0, 3'd0, 17'h0, 8'h0);

        // R2: short strobe inside a sequence neither breaks nor advances
        base = n_start;
        bus_wr(17'h05555, 8'hAA);
        bus_wr(17'h02AAA, 8'h55, 1);
        bus_wr(17'h02AAA, 8'h55);
        bus_wr(17'h05555, 8'hA0);
        bus_wr(17'h00777, 8'h99, 4);
        expect_op("R2", base, 1'b1, 3'd1, 17'h00777, 8'h99);
        // R2: short first write does not start a sequence
        base = n_start;
        bus_wr(17'h05555, 8'hAA, 1);
        bus_wr(17'h02AAA, 8'h55);
        bus_wr(17'h05555, 8'hA0);
        bus_wr(17'h00778, 8'h98);
        expect_op("R2", base, 1'b0, 3'd0, 17'h0, 8'h0);

        // R11: whole program while busy is dropped
        base = n_start;
        op_busy = 1'b1;
        unlock(); bus_wr(17'h05555, 8'hA0); bus_wr(17'h00100, 8'h01);
        op_busy = 1'b0;
        expect_op("R11", base, 1'b0, 3'd0, 17'h0, 8'h0);
        // R11: state held across busy writes
        base = n_start;
        unlock();
        op_busy = 1'b1;
        bus_wr(17'h03333, 8'h12);
        bus_wr(17'h05555, 8'h90);
        op_busy = 1'b0;
        bus_wr(17'h05555, 8'hA0);
        bus_wr(17'h00200, 8'h02);
        expect_op("R11", base, 1'b1, 3'd1, 17'h00200, 8'h02);

        // R12: exact pulse timing on the final write
        unlock(); bus_wr(17'h05555, 8'hA0);
        @(negedge clk);
        bus_addr = 17'h00300; bus_data = 8'h33; bus_we_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_we_n = 1'b1;
        @(negedge clk);
        check_eq("R12", "start after sampling edge", op_start, 0);
        @(negedge clk);
        check_eq("R12", "start one edge later", op_start, 1);
        @(negedge clk);
        check_eq("R12", "start width", op_start, 0);
        repeat (5) @(negedge clk);
        check_eq("R12", "kind held", op_kind, 1);
        check_eq("R12", "addr held", op_addr, 17'h00300);
        check_eq("R12", "data held", op_data, 8'h33);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule